// File: doc/BRIEF.md
# Retriggerable BCD Watchdog Countdown

This block is a watchdog and interval timer with a four-digit decimal period. Software sets the period, in hundredths of a second, through two byte-wide reload registers. Each register holds two BCD digits. A single-cycle tick enable paces the count, normally at 100 Hz. The timer counts down from the reload value. When it expires it raises a sticky flag, strobes a one-cycle expiry output and asserts an interrupt request, unless a mask bit holds the request off.

The timer is retriggerable. Any bus access to either reload register, read or write, reloads the countdown and clears the flag. Software that keeps touching a reload register in time therefore never sees the watchdog fire. If nobody services it, the timer reloads itself after every expiry and keeps firing at the same period. A reload value of zero switches the timer off.

The sequencing is a four-state machine. OFF is disabled and ignores ticks. LOAD copies the reload value into the counter. RUN decrements on each tick. FIRE marks an expiry and reloads. The transitions are named as follows:
- RESTART: any state to LOAD, on a reload-register access.
- ARM: LOAD to RUN, when the reload value is non-zero.
- DISARM: LOAD or FIRE to OFF, when the reload value is zero.
- EXPIRE: RUN to FIRE, on a tick while the count stands at one.
- REPEAT: FIRE to RUN.

Top module: `bcd_watchdog`

## Requirements
- R1: After reset the flag, interrupt request and expiry strobe are low. Every register reads 0x00, and ticks have no effect until the timer is armed.
- R2: Address 0 holds the low digits: tenths in bits 7:4 and hundredths in bits 3:0. Address 1 holds the high digits: tens of seconds in bits 7:4 and units in bits 3:0. Both always read back the last value written, never the running count. Address 3 reads 0x00.
- R3: Let N be the reload value counted in hundredths. After a reload access, the tick in the first following cycle is ignored. The flag rises and the expiry strobe pulses at the clock edge that samples the N-th tick counted from the second cycle after the access.
- R4: The countdown borrows through all four BCD digits. For example, a reload of 10.00 expires after exactly 1000 ticks and 99.99 after exactly 9999.
- R5: Without service, the timer reloads at each expiry. The tick in the cycle after the expiry is ignored, and the next expiry strobe follows after N further ticks. The flag stays set throughout.
- R6: A read or a write of address 0 or 1 clears the flag, the interrupt request and any pending expiry at the next clock edge, and restarts the count.
- R7: With both reload registers at zero, no number of ticks sets the flag or pulses the expiry strobe.
- R8: Control register (address 2) bit 1 reads the flag. Writes to address 2 leave the flag unchanged, and reading address 2 does not restart the count.
- R9: Control register bit 3 is a writable mask that reads back. When it is 1 the interrupt request is low; when it is 0 the request equals the flag. All other control bits read 0.
- R10: If a reload access and an expiring tick fall in the same cycle, the access wins: the flag stays clear, no strobe appears, and a full new period begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| tick | input | 1 | Count enable, one cycle per hundredth of a second |
| wd_flag | output | 1 | Sticky watchdog expiry flag |
| wd_irq | output | 1 | Interrupt request, flag gated by the mask |
| wd_fire | output | 1 | One-cycle strobe on every expiry |

## Verification
Read data is combinational, so the bench samples it within the access cycle. The flag, strobe and interrupt request change on the edge that samples the access or the expiring tick. Each reload access is followed by one idle cycle that covers LOAD. After that, exactly N-1 ticks are given and both outputs are checked low, then one more tick is given and both are checked high, with every sample taken at the falling edge that follows. The sweep covers every reload value from 00.01 to 00.40 plus several values that borrow across digits. Flag and strobe are compared against the period the bench computes from the value it wrote.

// File: rtl/bcd_wd_pkg.sv
`timescale 1ns/1ps
package bcd_wd_pkg;
    localparam int BYTE_W  = 8;
    localparam int DIGIT_W = 4;
    localparam int DIGITS_PER_BYTE = BYTE_W / DIGIT_W;

    localparam int CTRL_FLAG_BIT = 1;
    localparam int CTRL_MASK_BIT = 3;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_LOAD = 2'd1,
        WD_RUN  = 2'd2,
        WD_FIRE = 2'd3
    } wd_state_e;
endpackage

// File: rtl/bcd_wd_counter.sv
`timescale 1ns/1ps
module bcd_wd_counter
    import bcd_wd_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_en,
    input  logic                        dec_en,
    input  logic [DIGITS*DIGIT_W-1:0]   load_val,
    output logic                        at_one
);
    localparam int CNT_W = DIGITS * DIGIT_W;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_dec;
    logic [DIGITS:0]  borrow;

    // Each digit takes a borrow from the one below it and passes one up when it wraps 0 -> 9.
    assign borrow[0] = 1'b1;

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_digit
        logic [DIGIT_W-1:0] cur;
        assign cur = cnt_q[gi*DIGIT_W +: DIGIT_W];
        assign cnt_dec[gi*DIGIT_W +: DIGIT_W] =
            !borrow[gi]          ? cur :
            (cur == '0)          ? DIGIT_W'(9) :
                                   cur - DIGIT_W'(1);
        assign borrow[gi+1] = borrow[gi] && (cur == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_en) begin
            cnt_q <= load_val;
        end else if (dec_en) begin
            cnt_q <= cnt_dec;
        end
    end

    assign at_one = (cnt_q == CNT_ONE);

    logic unused_top_borrow;
    assign unused_top_borrow = borrow[DIGITS];
endmodule

// File: rtl/bcd_wd_fsm.sv
`timescale 1ns/1ps
module bcd_wd_fsm
    import bcd_wd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    input  logic reload_zero,
    input  logic at_one,
    output logic load_en,
    output logic dec_en,
    output logic expire
);
    wd_state_e state_q;
    wd_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
        end else begin
            state_d_apply: state_q <= state_d;
        end
    end

    // Transitions: RESTART dominates every other one
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:  state_d = WD_OFF;
            WD_LOAD: state_d = reload_zero ? WD_OFF : WD_RUN;     // DISARM / ARM
            WD_RUN:  state_d = (tick && at_one) ? WD_FIRE : WD_RUN; // EXPIRE
            WD_FIRE: state_d = reload_zero ? WD_OFF : WD_RUN;     // DISARM / REPEAT
            default: state_d = WD_OFF;
        endcase
        if (restart) begin
            state_d = WD_LOAD;                                    // RESTART
        end
    end

    // Outputs
    always_comb begin
        load_en = 1'b0;
        dec_en  = 1'b0;
        expire  = 1'b0;
        unique case (state_q)
            WD_OFF:  ;
            WD_LOAD: load_en = 1'b1;
            WD_RUN: begin
                dec_en = tick && !restart;
                expire = tick && at_one && !restart;
            end
            WD_FIRE: load_en = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/bcd_wd_regs.sv
`timescale 1ns/1ps
module bcd_wd_regs
    import bcd_wd_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int ADDR_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [BYTE_W-1:0]          reg_wdata,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic                       expire,
    output logic [BYTE_W-1:0]          reg_rdata,
    output logic [DIGITS*DIGIT_W-1:0]  reload_val,
    output logic                       reload_zero,
    output logic                       restart,
    output logic                       flag,
    output logic                       mask,
    output logic                       fire
);
    localparam int RELOAD_REGS = DIGITS / DIGITS_PER_BYTE;
    localparam logic [ADDR_W:0]   RELOAD_LIM = (ADDR_W+1)'(RELOAD_REGS);
    localparam logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'(RELOAD_REGS);

    logic [BYTE_W-1:0] reload_q [RELOAD_REGS];
    logic              flag_q;
    logic              mask_q;
    logic              fire_q;
    logic              ctrl_wr;

    assign restart = (reg_rd || reg_wr) && ({1'b0, reg_addr} < RELOAD_LIM);
    assign ctrl_wr = reg_wr && (reg_addr == CTRL_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < RELOAD_REGS; k++) begin
                reload_q[k] <= '0;
            end
        end else if (reg_wr) begin
            for (int k = 0; k < RELOAD_REGS; k++) begin
                if (reg_addr == ADDR_W'(k)) begin
                    reload_q[k] <= reg_wdata;
                end
            end
        end
    end

    for (genvar gk = 0; gk < RELOAD_REGS; gk++) begin : g_pack
        assign reload_val[gk*BYTE_W +: BYTE_W] = reload_q[gk];
    end

    assign reload_zero = (reload_val == '0);

    // The flag clears on a reload access, and that clear beats a same-cycle set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            fire_q <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            fire_q <= expire && !restart;
            if (restart) begin
                flag_q <= 1'b0;
            end else if (expire) begin
                flag_q <= 1'b1;
            end
            if (ctrl_wr) begin
                mask_q <= reg_wdata[CTRL_MASK_BIT];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < RELOAD_REGS; k++) begin
            if (reg_addr == ADDR_W'(k)) begin
                reg_rdata = reload_q[k];
            end
        end
        if (reg_addr == CTRL_ADDR) begin
            reg_rdata[CTRL_FLAG_BIT] = flag_q;
            reg_rdata[CTRL_MASK_BIT] = mask_q;
        end
    end

    assign flag = flag_q;
    assign mask = mask_q;
    assign fire = fire_q;
endmodule

// File: rtl/bcd_watchdog.sv
`timescale 1ns/1ps
module bcd_watchdog
    import bcd_wd_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [7:0]        reg_rdata,
    input  logic              tick,
    output logic              wd_flag,
    output logic              wd_irq,
    output logic              wd_fire
);
    localparam int CNT_W = DIGITS * DIGIT_W;

    logic [CNT_W-1:0] reload_val;
    logic             reload_zero;
    logic             restart;
    logic             mask;
    logic             load_en;
    logic             dec_en;
    logic             expire;
    logic             at_one;

    bcd_wd_regs #(.DIGITS(DIGITS), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .expire      (expire),
        .reg_rdata   (reg_rdata),
        .reload_val  (reload_val),
        .reload_zero (reload_zero),
        .restart     (restart),
        .flag        (wd_flag),
        .mask        (mask),
        .fire        (wd_fire)
    );

    bcd_wd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .tick        (tick),
        .reload_zero (reload_zero),
        .at_one      (at_one),
        .load_en     (load_en),
        .dec_en      (dec_en),
        .expire      (expire)
    );

    bcd_wd_counter #(.DIGITS(DIGITS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .dec_en   (dec_en),
        .load_val (reload_val),
        .at_one   (at_one)
    );

    assign wd_irq = wd_flag && !mask;
endmodule

// File: rtl/bcd_watchdog_chk.sv
`timescale 1ns/1ps
module bcd_watchdog_chk #(
    parameter int DIGITS = 4,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [7:0]        reg_rdata,
    input logic              tick,
    input logic              wd_flag,
    input logic              wd_irq,
    input logic              wd_fire
);
    localparam int RELOAD_REGS = DIGITS / 2;
    localparam logic [ADDR_W:0]   RELOAD_LIM = (ADDR_W+1)'(RELOAD_REGS);
    localparam logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'(RELOAD_REGS);

    logic reload_hit;
    assign reload_hit = (reg_rd || reg_wr) && ({1'b0, reg_addr} < RELOAD_LIM);

    a_r6_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reload_hit |=> (!wd_flag && !wd_irq && !wd_fire));

    a_r8_flag_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_flag && reg_wr && reg_addr == CTRL_ADDR) |=> wd_flag);

    a_r8_flag_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == CTRL_ADDR) |-> (reg_rdata[1] == wd_flag));

    a_r9_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == CTRL_ADDR && reg_wdata[3]) |=> !wd_irq);

    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> wd_flag);

    a_r3_fire_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        wd_fire |-> $past(tick));

    a_r5_fire_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wd_fire |-> wd_flag);

    a_r3_flag_rise_with_fire: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag) |-> wd_fire);
endmodule

bind bcd_watchdog bcd_watchdog_chk #(.DIGITS(DIGITS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .tick      (tick),
    .wd_flag   (wd_flag),
    .wd_irq    (wd_irq),
    .wd_fire   (wd_fire)
);

// File: tb/test_bcd_watchdog.sv
`timescale 1ns/1ps
module test_bcd_watchdog;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       tick = 1'b0;
    logic       wd_flag;
    logic       wd_irq;
    logic       wd_fire;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    bcd_watchdog i_bcd_watchdog (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .tick(tick),
        .wd_flag(wd_flag), .wd_irq(wd_irq), .wd_fire(wd_fire)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] to_bcd(input int v);
        return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    endfunction

    // All tasks start and end just after a falling edge.
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic arm(input int v);
        logic [15:0] b;
        b = to_bcd(v);
        bus_write(2'd0, b[7:0]);
        bus_write(2'd1, b[15:8]);
        idle(1);
    endtask

    // Period test: silent for N-1 ticks, fires on the N-th
    task automatic period(input string req, input int v);
        ticks(v - 1);
        chk(req, {wd_flag, wd_fire}, 2'b00);
        ticks(1);
        chk(req, {wd_flag, wd_fire}, 2'b11);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog timeout");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 outputs", {wd_flag, wd_irq, wd_fire}, 3'b000);
        bus_read(2'd2, rd); chk("R1 ctrl", rd, 8'h00);
        bus_read(2'd0, rd); chk("R1 reload lo", rd, 8'h00);
        bus_read(2'd1, rd); chk("R1 reload hi", rd, 8'h00);
        ticks(20);
        chk("R1 idle ticks", {wd_flag, wd_fire}, 2'b00);

        // R2 readback and layout
        bus_write(2'd0, 8'h59);
        bus_write(2'd1, 8'h73);
        bus_read(2'd0, rd); chk("R2 lo", rd, 8'h59);
        bus_read(2'd1, rd); chk("R2 hi", rd, 8'h73);
        bus_read(2'd3, rd); chk("R2 unmapped", rd, 8'h00);

        // R3 sweep of small reload values
        for (int v = 1; v <= 40; v++) begin
            arm(v);
            period("R3 sweep", v);
        end

        // R3 with ticks spaced apart
        arm(7);
        repeat (6) begin ticks(1); idle(2); end
        chk("R3 spaced", {wd_flag, wd_fire}, 2'b00);
        ticks(1);
        chk("R3 spaced", {wd_flag, wd_fire}, 2'b11);

        // R4 borrows across digits
        arm(100);  period("R4 100", 100);
        arm(1000); period("R4 1000", 1000);
        arm(990);  period("R4 990", 990);
        arm(9999); period("R4 9999", 9999);
        bus_read(2'd0, rd); chk("R2 count hidden lo", rd, 8'h99);
        bus_read(2'd1, rd); chk("R2 count hidden hi", rd, 8'h99);

        // R5 auto-repeat
        arm(5);
        period("R5 first", 5);
        for (int p = 0; p < 3; p++) begin
            idle(1);
            ticks(4);
            chk("R5 repeat quiet", {wd_flag, wd_fire}, 2'b10);
            ticks(1);
            chk("R5 repeat fire", {wd_flag, wd_fire}, 2'b11);
        end

        // R9 and R8 mask and flag read-only
        chk("R9 irq unmasked", wd_irq, 1'b1);
        bus_write(2'd2, 8'h08);
        chk("R9 irq masked", {wd_flag, wd_irq}, 2'b10);
        bus_read(2'd2, rd); chk("R9 ctrl read", rd, 8'h0A);
        bus_write(2'd2, 8'hF5);
        bus_read(2'd2, rd); chk("R8 ctrl write keeps flag", rd, 8'h02);
        chk("R9 irq follows flag", wd_irq, 1'b1);

        // R6 reads and writes restart
        bus_read(2'd1, rd);
        chk("R6 read clears", {wd_flag, wd_irq, wd_fire}, 3'b000);
        arm(10);
        ticks(9);
        bus_read(2'd0, rd);
        idle(1);
        ticks(9);
        chk("R6 restarted", wd_flag, 1'b0);
        ticks(1);
        chk("R6 fires after restart", {wd_flag, wd_fire}, 2'b11);
        bus_write(2'd1, 8'h00);
        chk("R6 write clears", {wd_flag, wd_irq}, 2'b00);

        // R8 control read does not restart
        arm(10);
        ticks(5);
        bus_read(2'd2, rd);
        period("R8 ctrl read no restart", 5);

        // R10 access and expiring tick together
        arm(6);
        ticks(5);
        reg_addr = 2'd0; reg_rd = 1'b1; tick = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; tick = 1'b0;
        chk("R10 access wins", {wd_flag, wd_fire}, 2'b00);
        idle(1);
        period("R10 full period", 6);

        // R7 zero reload disables
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'h00);
        chk("R7 cleared", wd_flag, 1'b0);
        idle(1);
        for (int i = 0; i < 30; i++) begin
            ticks(1);
            chk("R7 no fire", {wd_flag, wd_fire}, 2'b00);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule